// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a two-part logical address, a segment number together with an offset inside that segment, into a physical address. It holds a small segment table in internal registers. Each entry carries a physical start address, a segment length, a validity flag and three access rights: read, write and execute. Software fills the table one entry per cycle through a write port. The number of segments that the running program may use comes in on a separate length input.

Every request is checked in a fixed order. The segment number is compared against the table length first. The entry's validity flag is checked next, then the offset against the segment length, and then the requested access against the entry's rights. The first check that fails sets the trap cause. When every check passes, the physical address is the entry's start address plus the offset. The result is registered, so it appears one cycle after the request together with a valid strobe.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_valid_o` is 0 and every table entry is invalid, so a request to any in-range segment traps with cause 2.
- R2: `rsp_valid_o` is 1 in the cycle after a cycle with `req_i`=1, and 0 in the cycle after a cycle with `req_i`=0. When it is 0, `rsp_trap_o` is 0.
- R3: A request with `req_seg_i` >= `tbl_len_i` traps with cause 1.
- R4: A request to a segment whose entry has its valid bit at 0 traps with cause 2.
- R5: A request whose offset is greater than or equal to the entry's limit (unsigned) traps with cause 3.
- R6: Access codes are 0 read, 1 write, 2 execute and 3 reserved. The rights field has bit 0 read, bit 1 write and bit 2 execute. A request whose right bit is 0 traps with cause 4, and code 3 always traps with cause 4.
- R7: A request that passes every check gives `rsp_trap_o`=0, cause 0 and `rsp_addr_o` = base + offset modulo 2^PA_W.
- R8: When several checks fail, the cause reported is the first failing one in the order 1, 2, 3, 4.
- R9: A write through the table port changes lookups from the next cycle on. A lookup in the same cycle as the write sees the old entry.
- R10: A trapped response drives `rsp_addr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table entry write enable |
| wr_idx_i | input | SEG_W | Entry to write |
| wr_base_i | input | PA_W | Segment physical start address |
| wr_limit_i | input | OFF_W+1 | Segment length |
| wr_valid_i | input | 1 | Entry valid flag |
| wr_rights_i | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| tbl_len_i | input | SEG_W+1 | Number of legal segments |
| req_i | input | 1 | Translation request strobe |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset inside the segment |
| req_acc_i | input | 2 | Access type code |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_addr_o | output | PA_W | Physical address, 0 on a trap |
| rsp_trap_o | output | 1 | Request trapped |
| rsp_cause_o | output | 3 | Trap cause: 0 none, 1 segment range, 2 invalid, 3 limit, 4 rights |

## Verification
The assertions assume that `tbl_len_i` and the request fields are stable around the clock edge and that `tbl_len_i` never exceeds the table size. The bench changes every input only at the falling edge and picks the length from 0 up to the table size. The properties on the segment-range cause and on the reserved access code do not depend on the table contents. The bench fills the table with a mix of valid and invalid entries and zero and full-range limits, and it places offsets just below and at each limit so that every cause and the ordering between them are reached.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_RANGE = 3'd1,
    CAUSE_INVAL = 3'd2,
    CAUSE_LIMIT = 3'd3,
    CAUSE_PRIV  = 3'd4
  } cause_e;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
  localparam int RIGHTS_W = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16,
  parameter int LIM_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [LIM_W-1:0] wr_limit_i,
  input  logic             wr_valid_i,
  input  logic [2:0]       wr_rights_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [LIM_W-1:0] rd_limit_o,
  output logic             rd_valid_o,
  output logic [2:0]       rd_rights_o
);
  localparam int NUM_SEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q   [NUM_SEG];
  logic [LIM_W-1:0] limit_q  [NUM_SEG];
  logic             valid_q  [NUM_SEG];
  logic [2:0]       rights_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == SEG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]   <= '0;
        limit_q[g]  <= '0;
        valid_q[g]  <= 1'b0;
        rights_q[g] <= '0;
      end else if (hit) begin
        base_q[g]   <= wr_base_i;
        limit_q[g]  <= wr_limit_i;
        valid_q[g]  <= wr_valid_i;
        rights_q[g] <= wr_rights_i;
      end
    end
  end

  // read sees registered state: same-cycle write is not visible
  assign rd_base_o   = base_q[rd_idx_i];
  assign rd_limit_o  = limit_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_rights_o = rights_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int LIM_W = 13
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       acc_i,
  input  logic [SEG_W:0]   tbl_len_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             valid_i,
  input  logic [2:0]       rights_i,
  output logic             trap_o,
  output logic [2:0]       cause_o,
  output logic [PA_W-1:0]  addr_o
);
  logic range_bad, limit_bad, priv_bad;

  assign range_bad = {1'b0, seg_i} >= tbl_len_i;
  assign limit_bad = LIM_W'(off_i) >= limit_i;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  priv_bad = !rights_i[RIGHT_R];
      ACC_WRITE: priv_bad = !rights_i[RIGHT_W];
      ACC_EXEC:  priv_bad = !rights_i[RIGHT_X];
      default:   priv_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (range_bad)      cause_o = CAUSE_RANGE;
    else if (!valid_i)  cause_o = CAUSE_INVAL;
    else if (limit_bad) cause_o = CAUSE_LIMIT;
    else if (priv_bad)  cause_o = CAUSE_PRIV;
    else                cause_o = CAUSE_NONE;
  end

  assign trap_o = (cause_o != CAUSE_NONE);
  assign addr_o = trap_o ? '0 : base_i + PA_W'(off_i);
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int PA_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            trap_i,
  input  logic [2:0]      cause_i,
  input  logic [PA_W-1:0] addr_i,
  output logic            valid_o,
  output logic            trap_o,
  output logic [2:0]      cause_o,
  output logic [PA_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      trap_o  <= 1'b0;
      cause_o <= '0;
      addr_o  <= '0;
    end else begin
      valid_o <= req_i;
      trap_o  <= req_i & trap_i;
      cause_o <= req_i ? cause_i : '0;
      addr_o  <= req_i ? addr_i : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEG_W-1:0]   wr_idx_i,
  input  logic [PA_W-1:0]    wr_base_i,
  input  logic [OFF_W:0]     wr_limit_i,
  input  logic               wr_valid_i,
  input  logic [2:0]         wr_rights_i,
  input  logic [SEG_W:0]     tbl_len_i,
  input  logic               req_i,
  input  logic [SEG_W-1:0]   req_seg_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [1:0]         req_acc_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_addr_o,
  output logic               rsp_trap_o,
  output logic [2:0]         rsp_cause_o
);
  localparam int LIM_W = OFF_W + 1;

  logic [PA_W-1:0]  ent_base;
  logic [LIM_W-1:0] ent_limit;
  logic             ent_valid;
  logic [2:0]       ent_rights;
  logic             chk_trap;
  logic [2:0]       chk_cause;
  logic [PA_W-1:0]  chk_addr;

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_base_i   (wr_base_i),
    .wr_limit_i  (wr_limit_i),
    .wr_valid_i  (wr_valid_i),
    .wr_rights_i (wr_rights_i),
    .rd_idx_i    (req_seg_i),
    .rd_base_o   (ent_base),
    .rd_limit_o  (ent_limit),
    .rd_valid_o  (ent_valid),
    .rd_rights_o (ent_rights)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
    .seg_i     (req_seg_i),
    .off_i     (req_off_i),
    .acc_i     (req_acc_i),
    .tbl_len_i (tbl_len_i),
    .base_i    (ent_base),
    .limit_i   (ent_limit),
    .valid_i   (ent_valid),
    .rights_i  (ent_rights),
    .trap_o    (chk_trap),
    .cause_o   (chk_cause),
    .addr_o    (chk_addr)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .trap_i  (chk_trap),
    .cause_i (chk_cause),
    .addr_i  (chk_addr),
    .valid_o (rsp_valid_o),
    .trap_o  (rsp_trap_o),
    .cause_o (rsp_cause_o),
    .addr_o  (rsp_addr_o)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEG_W:0]   tbl_len_i,
  input logic             req_i,
  input logic [SEG_W-1:0] req_seg_i,
  input logic [1:0]       req_acc_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_addr_o,
  input logic             rsp_trap_o,
  input logic [2:0]       rsp_cause_o
);
  // R2
  req_to_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  // R2
  idle_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !rsp_trap_o);

  // R3
  seg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, req_seg_i} >= tbl_len_i)) |=> rsp_trap_o && rsp_cause_o == 3'd1);

  // R6
  rsvd_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_acc_i == 2'd3 && ({1'b0, req_seg_i} < tbl_len_i))
      |=> rsp_trap_o && rsp_cause_o != 3'd0 && rsp_cause_o != 3'd1);

  // R10
  trap_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_trap_o) |-> rsp_addr_o == '0);

  // R7
  cause_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_trap_o == (rsp_cause_o != 3'd0)) && rsp_cause_o <= 3'd4);
endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tbl_len_i   (tbl_len_i),
  .req_i       (req_i),
  .req_seg_i   (req_seg_i),
  .req_acc_i   (req_acc_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_trap_o  (rsp_trap_o),
  .rsp_cause_o (rsp_cause_o)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int NSEG  = 1 << SEG_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [SEG_W-1:0] wr_idx_i = '0;
  logic [PA_W-1:0]  wr_base_i = '0;
  logic [OFF_W:0]   wr_limit_i = '0;
  logic             wr_valid_i = 1'b0;
  logic [2:0]       wr_rights_i = '0;
  logic [SEG_W:0]   tbl_len_i = '0;
  logic             req_i = 1'b0;
  logic [SEG_W-1:0] req_seg_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [1:0]       req_acc_i = '0;
  logic             rsp_valid_o;
  logic [PA_W-1:0]  rsp_addr_o;
  logic             rsp_trap_o;
  logic [2:0]       rsp_cause_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (.*);

  // reference model
  int m_base [NSEG];
  int m_limit[NSEG];
  bit m_valid[NSEG];
  int m_rights[NSEG];
  bit exp_v;
  int exp_cause;
  int exp_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSEG; i++) begin
        m_base[i] = 0; m_limit[i] = 0; m_valid[i] = 0; m_rights[i] = 0;
      end
      exp_v = 0; exp_cause = 0; exp_addr = 0;
    end else begin
      exp_v = req_i;
      exp_cause = 0;
      exp_addr = 0;
      if (req_i) begin
        int s, o, a;
        bit ok_acc;
        s = int'(req_seg_i); o = int'(req_off_i); a = int'(req_acc_i);
        ok_acc = (a < 3) && (((m_rights[s] >> a) & 1) == 1);
        if (s >= int'(tbl_len_i))   exp_cause = 1;
        else if (!m_valid[s])       exp_cause = 2;
        else if (o >= m_limit[s])   exp_cause = 3;
        else if (!ok_acc)           exp_cause = 4;
        else exp_addr = (m_base[s] + o) % (1 << PA_W);
      end
      if (wr_en_i) begin
        m_base[wr_idx_i]   = int'(wr_base_i);
        m_limit[wr_idx_i]  = int'(wr_limit_i);
        m_valid[wr_idx_i]  = wr_valid_i;
        m_rights[wr_idx_i] = int'(wr_rights_i);
      end
    end
  end

  function automatic string tag_of(bit v, int c);
    if (!v) return "R2";
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (rsp_valid_o !== exp_v ||
          (exp_v && (rsp_cause_o !== 3'(exp_cause) || rsp_trap_o !== (exp_cause != 0) ||
                     rsp_addr_o !== PA_W'(exp_addr))) ||
          (!exp_v && rsp_trap_o !== 1'b0)) begin
        fails++;
        $display("FAIL %s%s: valid=%0d trap=%0d cause=%0d addr=%h exp valid=%0d cause=%0d addr=%h",
                 tag_of(exp_v, exp_cause), (exp_v && exp_cause != 0) ? "/R10" : "",
                 rsp_valid_o, rsp_trap_o, rsp_cause_o, rsp_addr_o, exp_v, exp_cause, exp_addr[PA_W-1:0]);
      end
    end
  end

  task automatic do_wr(input int idx, input int base, input int lim, input bit v, input int rt);
    wr_en_i = 1'b1; wr_idx_i = SEG_W'(idx); wr_base_i = PA_W'(base);
    wr_limit_i = (OFF_W+1)'(lim); wr_valid_i = v; wr_rights_i = 3'(rt);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_req(input int seg, input int off, input int acc,
                        input int ecause, input int eaddr, input string tag);
    req_i = 1'b1; req_seg_i = SEG_W'(seg); req_off_i = OFF_W'(off); req_acc_i = 2'(acc);
    @(negedge clk_i);
    wr_en_i = 1'b0; req_i = 1'b0;
    checks++;
    if (!rsp_valid_o || rsp_cause_o !== 3'(ecause) || rsp_addr_o !== PA_W'(eaddr)) begin
      fails++;
      $display("FAIL %s: valid=%0d cause=%0d addr=%h exp cause=%0d addr=%h",
               tag, rsp_valid_o, rsp_cause_o, rsp_addr_o, ecause, eaddr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid_o=%0d exp 0", rsp_valid_o);
    end
    rst_ni = 1'b1;
    tbl_len_i = 4'd8;
    @(negedge clk_i);
    // R1: all entries invalid after reset
    do_req(5, 0, 0, 2, 0, "R1");
    do_req(0, 0, 2, 2, 0, "R1");
    // R9: write and lookup in the same cycle sees old entry
    wr_en_i = 1'b1; wr_idx_i = 3'd2; wr_base_i = 16'h1000; wr_limit_i = 13'h100;
    wr_valid_i = 1'b1; wr_rights_i = 3'b101;
    do_req(2, 'h20, 0, 2, 0, "R9");
    do_req(2, 'h20, 0, 0, 'h1020, "R9");
    // R6
    do_req(2, 'h20, 1, 4, 0, "R6");
    do_req(2, 'h20, 3, 4, 0, "R6");
    do_req(2, 'h20, 2, 0, 'h1020, "R6");
    // R5 and R10: limit boundary
    do_req(2, 'h100, 0, 3, 0, "R5");
    do_req(2, 'hFF, 0, 0, 'h10FF, "R5");
    // R3 and R8
    tbl_len_i = 4'd2;
    do_req(2, 'h20, 0, 1, 0, "R3");
    do_req(6, 'hFFF, 3, 1, 0, "R8");
    tbl_len_i = 4'd8;
    do_req(6, 'hFFF, 3, 2, 0, "R8");
    do_req(2, 'h200, 1, 3, 0, "R8");
    // R4: entry explicitly written invalid
    do_wr(4, 'h2000, 'h1000, 1'b0, 7);
    do_req(4, 0, 0, 2, 0, "R4");
    // R7: address wraps modulo 2^PA_W
    do_wr(3, 'hFFF0, 'h1000, 1'b1, 7);
    do_req(3, 'h20, 1, 0, 'h0010, "R7");
    do_req(3, 'hFFF, 0, 0, 'h0FEF, "R7");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int s;
      wr_en_i = ($urandom % 4) == 0;
      wr_idx_i = SEG_W'($urandom);
      wr_base_i = PA_W'($urandom);
      case ($urandom % 4)
        0: wr_limit_i = '0;
        1: wr_limit_i = 13'h1000;
        2: wr_limit_i = 13'($urandom % 64);
        default: wr_limit_i = 13'($urandom % 13'h1001);
      endcase
      wr_valid_i = ($urandom % 4) != 0;
      wr_rights_i = 3'($urandom);
      if (($urandom % 16) == 0) tbl_len_i = 4'($urandom % 9);
      req_i = ($urandom % 3) != 0;
      s = int'($urandom % NSEG);
      req_seg_i = SEG_W'(s);
      case ($urandom % 4)
        0: req_off_i = OFF_W'(m_limit[s] - 1);
        1: req_off_i = OFF_W'(m_limit[s]);
        default: req_off_i = OFF_W'($urandom);
      endcase
      req_acc_i = 2'($urandom);
      @(negedge clk_i);
    end
    req_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule